// File: doc/BRIEF.md
# 100BASE-TX Transmit Symbol Coder

This block turns a nibble-wide transmit stream from a MAC into the serial three-level symbol stream of a 100 Mb/s twisted-pair line. Each nibble becomes one 5-bit code group, so one nibble is taken for every five symbol clocks. A frame opens with a start-of-stream delimiter that stands in for the first preamble octet and closes with an end-of-stream delimiter. All-ones idle groups fill the line between frames. Every code bit, idle included, is XORed with an 11-bit scrambler sequence. The scrambled bit then drives an MLT-3 level machine whose level leaves the block as a two-bit signed code.

The nibble input is a valid/ready stream with a one-deep holding register. `in_ready` is high exactly when the holding register is empty. A nibble is taken on a clock edge where `in_valid` and `in_ready` are both high. The source must hold `in_valid`, `in_nibble` and `in_last` stable while `in_ready` is low. The holding register is emptied only at a code-group boundary, so back-pressure lasts at most five cycles. Within a frame the source must supply each nibble before the next group boundary. A missed boundary is an underrun, and the line reports it with a halt group.

Top module: `tx100_sym_coder`

## Requirements
- R1: While reset is held and right after it, `line_sym` is 0 (2'b00) and `in_ready` is 1. The first five code bits after reset are idle ones.
- R2: When no frame is in progress, every code group is idle, 11111.
- R3: The first two nibbles of a frame are consumed without being coded. In their place the block sends J = 11000 and then K = 10001.
- R4: Each nibble after the second is sent as its 4B5B group, most significant bit first. The groups are 0=11110, 1=01001, 2=10100, 3=10101, 4=01010, 5=01011, 6=01110, 7=01111, 8=10010, 9=10011, A=10110, B=10111, C=11010, D=11011, E=11100, F=11101.
- R5: The group for the nibble flagged by `in_last` is followed at once by T = 01101 and then R = 00111. Idle follows unless another frame is waiting.
- R6: The line bit is the code bit XOR the scrambler key. A line bit of 1 advances the level one step through the cycle 0, +1, 0, −1. A line bit of 0 holds the level. The level appears on `line_sym` one clock after its bit, encoded as 2'b01 for +1, 2'b00 for 0 and 2'b11 for −1. The code 2'b10 never appears.
- R7: The scrambler is an 11-bit register loaded with `SCR_SEED` (default 11'h5A3, nonzero) at reset. Each clock its key is bit 10 XOR bit 8, and the register shifts left with the key entering at bit 0.
- R8: `in_ready` equals "holding register empty". It drops on the clock after an accept and rises again on the clock after the next group boundary. Group boundaries come every five clocks. A nibble accepted on a boundary edge waits for the following boundary.
- R9: If a frame is past K and no nibble is held at a group boundary, the block sends the halt group 00100. It stays in the frame.
- R10: If `in_last` marks the first or second nibble of a frame, the block sends J and K and then T and R, with no data groups.
- R11: If the first nibble of a new frame is held when R ends, J follows R directly, with no idle group between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Symbol clock, one code bit per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Source offers a nibble |
| in_ready | output | 1 | Holding register empty, nibble will be taken |
| in_nibble | input | 4 | Transmit nibble |
| in_last | input | 1 | Marks the last nibble of a frame |
| line_sym | output | 2 | MLT-3 level: 01 = +1, 00 = 0, 11 = −1 |

## Verification
The hardest situations to reach from the ports are those where a group boundary finds the holding register in an unusual state. These are an empty register in the middle of a frame, a frame that ends on its first or second nibble, and a new frame already waiting as R finishes. The stimulus creates each one directly. It pauses the source for more than a group time partway through a frame. It sends one-nibble and two-nibble frames. It offers the next frame's first nibble as soon as the previous last nibble has been taken. A behavioural reference, built from queues and its own scrambler, predicts the line level and `in_ready` for every clock and tags each code group with the requirement that governs it.

// File: rtl/tx100_sym_pkg.sv
package tx100_sym_pkg;

  localparam int GRP_W = 5;
  localparam int NIB_W = 4;

  typedef logic [GRP_W-1:0] cgrp_t;

  localparam cgrp_t CG_IDLE = 5'b11111;
  localparam cgrp_t CG_J    = 5'b11000;
  localparam cgrp_t CG_K    = 5'b10001;
  localparam cgrp_t CG_T    = 5'b01101;
  localparam cgrp_t CG_R    = 5'b00111;
  localparam cgrp_t CG_HALT = 5'b00100;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_K,
    SQ_DATA,
    SQ_T,
    SQ_R
  } seq_t;

  function automatic cgrp_t enc_4b5b(input logic [NIB_W-1:0] n);
    cgrp_t g;
    case (n)
      4'h0: g = 5'b11110;
      4'h1: g = 5'b01001;
      4'h2: g = 5'b10100;
      4'h3: g = 5'b10101;
      4'h4: g = 5'b01010;
      4'h5: g = 5'b01011;
      4'h6: g = 5'b01110;
      4'h7: g = 5'b01111;
      4'h8: g = 5'b10010;
      4'h9: g = 5'b10011;
      4'hA: g = 5'b10110;
      4'hB: g = 5'b10111;
      4'hC: g = 5'b11010;
      4'hD: g = 5'b11011;
      4'hE: g = 5'b11100;
      default: g = 5'b11101;
    endcase
    return g;
  endfunction

endpackage

// File: rtl/tx100_grp_sel.sv
module tx100_grp_sel
  import tx100_sym_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [NIB_W-1:0] in_nibble,
  input  logic             in_last,
  output logic             in_ready,
  input  logic             grp_load,
  output cgrp_t            grp_next
);

  logic             hold_v;
  logic [NIB_W-1:0] hold_nib;
  logic             hold_last;
  seq_t             seq_q, seq_d;
  logic             end_q, end_d;
  logic             take;

  assign in_ready = ~hold_v;

  always_comb begin
    seq_d    = seq_q;
    end_d    = end_q;
    take     = 1'b0;
    grp_next = CG_IDLE;
    case (seq_q)
      SQ_IDLE: begin
        if (hold_v) begin
          grp_next = CG_J;
          take     = 1'b1;
          end_d    = hold_last;
          seq_d    = SQ_K;
        end
      end
      SQ_K: begin
        grp_next = CG_K;
        take     = ~end_q & hold_v;
        end_d    = end_q | (take & hold_last);
        seq_d    = end_d ? SQ_T : SQ_DATA;
      end
      SQ_DATA: begin
        if (hold_v) begin
          grp_next = enc_4b5b(hold_nib);
          take     = 1'b1;
          seq_d    = hold_last ? SQ_T : SQ_DATA;
        end else begin
          grp_next = CG_HALT;
        end
      end
      SQ_T: begin
        grp_next = CG_T;
        seq_d    = SQ_R;
      end
      SQ_R: begin
        grp_next = CG_R;
        end_d    = 1'b0;
        seq_d    = SQ_IDLE;
      end
      default: seq_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq_q <= SQ_IDLE;
      end_q <= 1'b0;
    end else if (grp_load) begin
      seq_q <= seq_d;
      end_q <= end_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_v    <= 1'b0;
      hold_nib  <= '0;
      hold_last <= 1'b0;
    end else if (in_valid && in_ready) begin
      hold_v    <= 1'b1;
      hold_nib  <= in_nibble;
      hold_last <= in_last;
    end else if (grp_load && take) begin
      hold_v    <= 1'b0;
    end
  end

endmodule

// File: rtl/tx100_serializer.sv
module tx100_serializer
  import tx100_sym_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  cgrp_t grp_next,
  output logic  grp_load,
  output logic  code_bit
);

  localparam int CW = $clog2(GRP_W);
  localparam logic [CW-1:0] LAST_POS = CW'(GRP_W - 1);

  logic [CW-1:0] pos_q;
  cgrp_t         sh_q;

  assign grp_load = (pos_q == LAST_POS);
  assign code_bit = sh_q[GRP_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
      sh_q  <= CG_IDLE;
    end else if (grp_load) begin
      pos_q <= '0;
      sh_q  <= grp_next;
    end else begin
      pos_q <= pos_q + 1'b1;
      sh_q  <= {sh_q[GRP_W-2:0], 1'b0};
    end
  end

endmodule

// File: rtl/tx100_scrambler.sv
module tx100_scrambler #(
  parameter int         LFSR_W = 11,
  parameter int         TAP    = 9,
  parameter logic [10:0] SEED  = 11'h5A3
) (
  input  logic clk,
  input  logic rst_n,
  output logic key
);

  logic [LFSR_W-1:0] s_q;

  assign key = s_q[LFSR_W-1] ^ s_q[TAP-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) s_q <= LFSR_W'(SEED);
    else        s_q <= {s_q[LFSR_W-2:0], key};
  end

endmodule

// File: rtl/tx100_mlt3.sv
module tx100_mlt3 (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_in,
  output logic [1:0] line_sym
);

  logic [1:0] phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      phase_q <= 2'd0;
    else if (bit_in) phase_q <= phase_q + 2'd1;
  end

  always_comb begin
    case (phase_q)
      2'd1:    line_sym = 2'b01;
      2'd3:    line_sym = 2'b11;
      default: line_sym = 2'b00;
    endcase
  end

endmodule

// File: rtl/tx100_sym_coder.sv
module tx100_sym_coder
  import tx100_sym_pkg::*;
#(
  parameter int          SCR_W    = 11,
  parameter int          SCR_TAP  = 9,
  parameter logic [10:0] SCR_SEED = 11'h5A3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [3:0] in_nibble,
  input  logic       in_last,
  output logic [1:0] line_sym
);

  cgrp_t grp_next;
  logic  grp_load;
  logic  code_bit;
  logic  key;
  logic  scr_bit;

  tx100_grp_sel u_sel (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_nibble(in_nibble),
    .in_last  (in_last),
    .in_ready (in_ready),
    .grp_load (grp_load),
    .grp_next (grp_next)
  );

  tx100_serializer u_ser (
    .clk     (clk),
    .rst_n   (rst_n),
    .grp_next(grp_next),
    .grp_load(grp_load),
    .code_bit(code_bit)
  );

  tx100_scrambler #(
    .LFSR_W(SCR_W),
    .TAP   (SCR_TAP),
    .SEED  (SCR_SEED)
  ) u_scr (
    .clk  (clk),
    .rst_n(rst_n),
    .key  (key)
  );

  assign scr_bit = code_bit ^ key;

  tx100_mlt3 u_mlt (
    .clk     (clk),
    .rst_n   (rst_n),
    .bit_in  (scr_bit),
    .line_sym(line_sym)
  );

endmodule

// File: rtl/tx100_sym_coder_chk.sv
module tx100_sym_coder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic       grp_load,
  input logic       scr_bit,
  input logic [1:0] line_sym
);

  logic [2:0] since_load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        since_load <= 3'd0;
    else if (grp_load) since_load <= 3'd0;
    else               since_load <= since_load + 3'd1;
  end

  p_level_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
    line_sym != 2'b10);

  p_zero_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !scr_bit |=> $stable(line_sym));

  p_one_moves_r6: assert property (@(posedge clk) disable iff (!rst_n)
    scr_bit |=> (line_sym != $past(line_sym)));

  p_no_rail_jump_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (line_sym == 2'b01) |=> (line_sym != 2'b11));

  p_group_period_r8: assert property (@(posedge clk) disable iff (!rst_n)
    grp_load == (since_load == 3'd4));

  p_accept_fills_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  p_stall_until_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_ready && !grp_load) |=> !in_ready);

endmodule

bind tx100_sym_coder tx100_sym_coder_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .in_valid(in_valid),
  .in_ready(in_ready),
  .grp_load(grp_load),
  .scr_bit (scr_bit),
  .line_sym(line_sym)
);

// File: tb/sim_tx100_sym_coder.sv
module sim_tx100_sym_coder;

  localparam int CLK_PERIOD = 10;
  localparam int SEED       = 'h5A3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [3:0] in_nibble = 4'h0;
  logic       in_last = 1'b0;
  logic [1:0] line_sym;

  int vectors = 0;
  int fails   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tx100_sym_coder u0 (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_nibble(in_nibble),
    .in_last  (in_last),
    .line_sym (line_sym)
  );

  // ---------------- reference model ----------------
  int         tbl [16] = '{'b11110, 'b01001, 'b10100, 'b10101, 'b01010, 'b01011,
                           'b01110, 'b01111, 'b10010, 'b10011, 'b10110, 'b10111,
                           'b11010, 'b11011, 'b11100, 'b11101};
  bit         bq[$];
  string      tq[$];
  logic [4:0] nq[$];
  int         lfsr, phase, mst;
  bit         mend, mshort, after_r, mready;
  string      last_tag;

  task automatic push_group(input int g, input string t);
    for (int i = 4; i >= 0; i--) begin
      bq.push_back(((g >> i) & 1) == 1);
      tq.push_back(t);
    end
  endtask

  task automatic gen_group();
    logic [4:0] e;
    case (mst)
      0: begin
        if (nq.size() != 0) begin
          e = nq.pop_front();
          push_group('b11000, after_r ? "R11" : "R3");
          mend = e[4]; mshort = e[4]; mst = 1;
        end else push_group('b11111, "R2");
        after_r = 0;
      end
      1: begin
        if (!mend && nq.size() != 0) begin
          e = nq.pop_front();
          mend = e[4]; mshort = e[4];
        end
        push_group('b10001, mshort ? "R10" : "R3");
        mst = mend ? 3 : 2;
      end
      2: begin
        if (nq.size() != 0) begin
          e = nq.pop_front();
          push_group(tbl[e[3:0]], "R4");
          mst = e[4] ? 3 : 2;
        end else push_group('b00100, "R9");
      end
      3: begin push_group('b01101, mshort ? "R10" : "R5"); mst = 4; end
      default: begin
        push_group('b00111, mshort ? "R10" : "R5");
        mst = 0; after_r = 1; mend = 0; mshort = 0;
      end
    endcase
  endtask

  function automatic logic [1:0] lvl(input int p);
    return (p == 1) ? 2'b01 : (p == 3) ? 2'b11 : 2'b00;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bq.delete(); tq.delete(); nq.delete();
      push_group('b11111, "R1");
      lfsr = SEED; phase = 0; mst = 0;
      mend = 0; mshort = 0; after_r = 0; mready = 1; last_tag = "R1";
    end else begin
      bit b, k;
      b = bq.pop_front();
      last_tag = tq.pop_front();
      k = (((lfsr >> 10) ^ (lfsr >> 8)) & 1) == 1;
      lfsr = ((lfsr << 1) | int'(k)) & 'h7FF;
      if (b ^ k) phase = (phase + 1) % 4;
      if (bq.size() == 0) gen_group();
      if (in_valid && mready) nq.push_back({in_last, in_nibble});
      mready = (nq.size() == 0);
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      vectors++;
      if (line_sym !== lvl(phase)) begin
        fails++;
        $display("FAIL %s/R6/R7 line_sym actual=%b expected=%b at %0t",
                 last_tag, line_sym, lvl(phase), $time);
      end
      vectors++;
      if (in_ready !== mready) begin
        fails++;
        $display("FAIL R8 in_ready actual=%b expected=%b at %0t",
                 in_ready, mready, $time);
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic push(input logic [3:0] n, input logic l);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_nibble = n; in_last = l;
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  task automatic frame(input int n_data, input int stall_at);
    for (int i = 0; i < 15; i++) push(4'h5, 1'b0);
    push(4'hD, 1'b0);
    for (int i = 0; i < n_data; i++) begin
      if (i == stall_at) repeat (13) @(negedge clk);
      push(4'(i), i == n_data - 1);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    vectors++;
    if (line_sym !== 2'b00 || in_ready !== 1'b1) begin
      fails++;
      $display("FAIL R1 reset line_sym/in_ready actual=%b/%b expected=00/1", line_sym, in_ready);
    end
    rst_n = 1'b1;
    repeat (30) @(negedge clk);               // R2 idle fill
    frame(24, -1);                            // R3 R4 R5, all 16 nibble values
    frame(8, -1);                             // R11 back-to-back
    repeat (23) @(negedge clk);
    frame(10, 4);                             // R9 underrun mid-frame
    repeat (17) @(negedge clk);
    push(4'h5, 1'b1);                         // R10 one-nibble frame
    repeat (12) @(negedge clk);
    push(4'h5, 1'b0); push(4'h5, 1'b1);       // R10 two-nibble frame
    repeat (60) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule